// File: doc/BRIEF.md
# Recentering Transmit Elastic FIFO

This block sits between the transmit parallel input and the serializer load stage. Four-bit words arrive on the rising edge of an upstream data clock. They are taken out on a local word clock, which is the serial clock divided by four. The two clocks share one nominal rate, but their phase is unknown and wanders slowly. The FIFO holds eight words. It absorbs any fixed phase offset between the clocks, plus up to three words of relative drift in either direction, and the word stream passes through unchanged.

All control lives on the read side. A recenter moves the read position so that it trails the write position by half the storage, four words. A recenter is triggered by the read-side reset, by holding the FIFO clear input high, or by a rising edge of the transmit lock indication. The write side only counts and stores words. It publishes its position to the read side as a Gray code through a two-flop synchronizer. The read side measures the apparent separation. When drift leaves the tolerated window it raises a sticky error flag. While that flag is set, or while a recenter is in progress, the read side sends all-zero words.

Top module: `tx_elastic_fifo`

## Requirements
- R1: While `rd_rst` is high, `rd_data` is zero and `fifo_err` is low.
- R2: After a recenter, with both clocks at the same rate, every written word appears on `rd_data` exactly once and in write order, so consecutive read words differ by one when the written words count up by one. The write position advances by one Gray-code step per write clock.
- R3: After a recenter, a net drift of up to three words, with the writer either behind or ahead of the reader, causes no error and breaks no part of the word order.
- R4: A net write deficit of four words after a recenter (approaching underflow) sets `fifo_err`.
- R5: A net write surplus of four words after a recenter (approaching overflow) sets `fifo_err`.
- R6: Once set, `fifo_err` stays high until `fifo_clr` or `rd_rst` is asserted. A rising edge of `tx_lock` does not clear it.
- R7: While `fifo_err` is high, `rd_data` is all zeros.
- R8: While `fifo_clr` is held high, `rd_data` is zero and `fifo_err` is cleared. After it is released, the read position is recentered and the words follow in order again.
- R9: A rising edge of `tx_lock` recenters the read position. This removes the accumulated drift, and it sends at least four all-zero words while the recenter runs.
- R10: A falling edge of `tx_lock` has no effect on the read position or on the word order.
- R11: Releasing `rd_rst` recenters the read position, so that order-preserving reads resume with the drift window centered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Upstream parallel data clock; words are written on its rising edge |
| wr_rst | input | 1 | Synchronous active-high reset of the write side |
| wr_data | input | 4 | Parallel data word from upstream |
| rd_clk | input | 1 | Local word clock (serial clock divided by four) |
| rd_rst | input | 1 | Synchronous active-high reset of the read side; recenters on release |
| fifo_clr | input | 1 | Level FIFO clear, asynchronous to both clocks; clears the error and recenters |
| tx_lock | input | 1 | Transmit PLL lock indication, asynchronous; a rising edge recenters |
| rd_data | output | 4 | Word handed to the serializer load stage, zero when blanked |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Two functions can meet in the same read cycle: error detection and a recenter request from the lock input. The sticky flag must survive that recenter, and the output must stay blank. The bench first pushes the writer four words behind the reader, which sets the flag. It then toggles `tx_lock` low and high and judges that `fifo_err` is still high and `rd_data` still zero. Only after that does it assert `fifo_clr` and expect the flag to drop. The bench also checks a second pairing: a falling lock edge while the FIFO sits at the edge of its drift window. Here an unwanted recenter would show up as a break in an otherwise counting word stream.

// File: rtl/txef_pkg.sv
package txef_pkg;

    localparam int WORD_W      = 4;
    localparam int DEPTH       = 8;
    localparam int AW          = $clog2(DEPTH);
    localparam int PW          = AW + 1;
    localparam int SYNC_STAGES = 2;
    localparam int HOLD_CYC    = 4;
    localparam int HOLD_W      = $clog2(HOLD_CYC + 1);
    // words by which the synchronized write position trails the live one
    localparam int SYNC_LAG    = 2;
    localparam int CENTER      = DEPTH / 2;
    localparam int EST_MID     = CENTER - SYNC_LAG;
    localparam int DRIFT_TOL   = 3;
    localparam int EST_LO      = EST_MID - DRIFT_TOL;
    localparam int EST_HI      = EST_MID + DRIFT_TOL;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PW-1:0]     ptr_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
    } wpos_t;

    typedef enum logic [1:0] {
        RD_RUN    = 2'd0,
        RD_CENTER = 2'd1,
        RD_FAULT  = 2'd2
    } rd_mode_e;

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/txef_sync.sv
module txef_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/txef_wr_ctrl.sv
module txef_wr_ctrl
    import txef_pkg::*;
(
    input  logic  wr_clk,
    input  logic  wr_rst,
    output wpos_t wpos
);
    ptr_t nxt;
    assign nxt = wpos.bin + ptr_t'(1);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wpos <= '0;
        end else begin
            wpos.bin  <= nxt;
            wpos.gray <= bin2gray(nxt);
        end
    end

    // R2: the published position moves one Gray step per write
    p_gray_step_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        1'b1 |=> $countones(wpos.gray ^ $past(wpos.gray)) == 1)
        else $error("write position Gray code moved more than one bit");
endmodule

// File: rtl/txef_store.sv
module txef_store
    import txef_pkg::*;
(
    input  logic          wr_clk,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_word,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_word
);
    word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        mem[wr_addr] <= wr_word;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/txef_rd_ctrl.sv
module txef_rd_ctrl
    import txef_pkg::*;
(
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  ptr_t          wgray_s,
    input  logic          clr_s,
    input  logic          lock_s,
    input  word_t         rd_word,
    output logic [AW-1:0] rd_addr,
    output word_t         rd_data,
    output logic          fifo_err
);
    localparam logic signed [PW-1:0] LO_S     = PW'(EST_LO);
    localparam logic signed [PW-1:0] HI_S     = PW'(EST_HI);
    localparam ptr_t                 LOAD_OFS = PW'(EST_MID - 1);
    localparam logic [HOLD_W-1:0]    HOLD_V   = HOLD_W'(HOLD_CYC);

    ptr_t              rptr;
    ptr_t              wbin_s;
    logic signed [PW-1:0] est;
    logic [HOLD_W-1:0] hold_cnt;
    logic              lock_d;
    logic              lock_rise;
    logic              centering;
    logic              beyond;
    logic              set_err;
    rd_mode_e          mode;

    assign wbin_s    = gray2bin(wgray_s);
    assign est       = $signed(wbin_s - rptr);
    assign lock_rise = lock_s & ~lock_d;
    assign centering = (hold_cnt != '0);
    assign beyond    = (est < LO_S) || (est > HI_S);
    assign set_err   = !centering && !clr_s && beyond;
    assign rd_addr   = rptr[AW-1:0];

    always_comb begin
        if (centering || clr_s)      mode = RD_CENTER;
        else if (fifo_err || set_err) mode = RD_FAULT;
        else                          mode = RD_RUN;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rptr     <= '0;
            hold_cnt <= HOLD_V;
            fifo_err <= 1'b0;
            rd_data  <= '0;
            lock_d   <= 1'b0;
        end else begin
            lock_d <= lock_s;

            if (clr_s || lock_rise) hold_cnt <= HOLD_V;
            else if (centering)     hold_cnt <= hold_cnt - 1'b1;

            if (clr_s)        fifo_err <= 1'b0;
            else if (set_err) fifo_err <= 1'b1;

            if (centering) rptr <= wbin_s - LOAD_OFS;
            else           rptr <= rptr + ptr_t'(1);

            case (mode)
                RD_RUN:  rd_data <= rd_word;
                default: rd_data <= '0;
            endcase
        end
    end

    // R6: error flag holds until the clear input or reset
    p_err_sticky_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        fifo_err && !clr_s |=> fifo_err)
        else $error("error flag dropped without a clear");

    // R7: blank output whenever the flag is up
    p_blank_on_err_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        fifo_err |-> rd_data == '0)
        else $error("data passed while error flag set");

    // R8: clear input drops the flag on the next word
    p_clr_clears_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        clr_s |=> !fifo_err)
        else $error("clear did not drop error flag");

    // R8/R9: a recenter in progress blanks the following word
    p_blank_center_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        centering |=> rd_data == '0)
        else $error("data passed during recenter");

    // R9: lock gain starts a recenter
    p_lock_rise_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(lock_s) |=> centering)
        else $error("lock edge did not recenter");
endmodule

// File: rtl/tx_elastic_fifo.sv
module tx_elastic_fifo
    import txef_pkg::*;
(
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic [3:0] wr_data,
    input  logic       rd_clk,
    input  logic       rd_rst,
    input  logic       fifo_clr,
    input  logic       tx_lock,
    output logic [3:0] rd_data,
    output logic       fifo_err
);
    wpos_t         wpos;
    ptr_t          wgray_s;
    logic [1:0]    ctl_s;
    logic [AW-1:0] rd_addr;
    word_t         rd_word;

    txef_wr_ctrl u_wr (
        .wr_clk (wr_clk),
        .wr_rst (wr_rst),
        .wpos   (wpos)
    );

    txef_store u_store (
        .wr_clk  (wr_clk),
        .wr_addr (wpos.bin[AW-1:0]),
        .wr_word (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    txef_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wpos.gray),
        .q   (wgray_s)
    );

    txef_sync #(.W(2), .STAGES(SYNC_STAGES)) u_csync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   ({tx_lock, fifo_clr}),
        .q   (ctl_s)
    );

    txef_rd_ctrl u_rd (
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .wgray_s  (wgray_s),
        .clr_s    (ctl_s[0]),
        .lock_s   (ctl_s[1]),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .fifo_err (fifo_err)
    );
endmodule

// File: tb/tx_elastic_fifo_tb_top.sv
module tx_elastic_fifo_tb_top;

    logic       wr_clk;
    logic       wr_rst;
    logic [3:0] wr_data;
    logic       rd_clk;
    logic       rd_rst;
    logic       fifo_clr;
    logic       tx_lock;
    logic [3:0] rd_data;
    logic       fifo_err;

    int n_chk = 0;
    int n_bad = 0;
    int pause_req = 0, pause_done = 0;
    int extra_req = 0, extra_done = 0;
    bit finished = 0;

    tx_elastic_fifo dut_i (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_data  (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .fifo_clr (fifo_clr),
        .tx_lock  (tx_lock),
        .rd_data  (rd_data),
        .fifo_err (fifo_err)
    );

    // write clock, 250 MHz nominal; can skip periods or squeeze in one extra word
    initial begin
        wr_clk  = 0;
        wr_data = 4'd0;
        forever begin
            if (pause_done < pause_req) begin
                #4;
                pause_done++;
            end else if (extra_done < extra_req) begin
                wr_clk = 1; #1; wr_clk = 0; wr_data = wr_data + 4'd1; #1;
                wr_clk = 1; #1; wr_clk = 0; wr_data = wr_data + 4'd1; #1;
                extra_done++;
            end else begin
                wr_clk = 1; #2; wr_clk = 0; wr_data = wr_data + 4'd1; #2;
            end
        end
    end

    // read word clock, 250 MHz, rising 1 ns after the write clock
    initial begin
        rd_clk = 0;
        #1;
        forever begin
            rd_clk = 1; #2; rd_clk = 0; #2;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd_cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic lag(input int k);
        pause_req += k;
        wait (pause_done == pause_req);
    endtask

    task automatic lead(input int k);
        extra_req += k;
        wait (extra_done == extra_req);
    endtask

    task automatic recenter_by_clr();
        fifo_clr = 1;
        rd_cycles(6);
        fifo_clr = 0;
        rd_cycles(12);
    endtask

    task automatic check_stream(input int n, input string req);
        int breaks = 0;
        int errs = 0;
        logic [3:0] prev;
        @(negedge rd_clk);
        prev = rd_data;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (rd_data != prev + 4'd1) breaks++;
            if (fifo_err) errs++;
            prev = rd_data;
        end
        chk(breaks == 0 && errs == 0, req, breaks + errs, 0);
    endtask

    task automatic t_reset();
        int bad = 0;
        fifo_clr = 0;
        tx_lock  = 1;
        wr_rst   = 1;
        rd_rst   = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge rd_clk);
            if (i >= 2 && (rd_data != 4'd0 || fifo_err)) bad++;
        end
        chk(bad == 0, "R1 reset state", bad, 0);
        wr_rst = 0;
        rd_rst = 0;
        rd_cycles(16);
        check_stream(24, "R2 steady in-order stream");
        check_stream(24, "R11 reset release recentered");
    endtask

    task automatic t_drift_ok();
        recenter_by_clr();
        lag(3);
        rd_cycles(8);
        check_stream(24, "R3 writer behind by three");
        recenter_by_clr();
        lead(3);
        rd_cycles(8);
        check_stream(24, "R3 writer ahead by three");
    endtask

    task automatic t_underflow_and_sticky();
        int nz = 0;
        recenter_by_clr();
        lag(4);
        rd_cycles(8);
        chk(fifo_err == 1'b1, "R4 underflow flagged", fifo_err, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge rd_clk);
            if (rd_data != 4'd0) nz++;
        end
        chk(nz == 0, "R7 blank while error", nz, 0);
        // lock drop and regain while the flag is set
        tx_lock = 0;
        rd_cycles(6);
        tx_lock = 1;
        rd_cycles(12);
        chk(fifo_err == 1'b1, "R6 flag survives lock edge", fifo_err, 1);
        chk(rd_data == 4'd0, "R7 still blank after lock edge", rd_data, 0);
        fifo_clr = 1;
        rd_cycles(6);
        chk(fifo_err == 1'b0, "R8 clear drops flag", fifo_err, 0);
        chk(rd_data == 4'd0, "R8 blank while clear held", rd_data, 0);
        fifo_clr = 0;
        rd_cycles(12);
        check_stream(16, "R8 order resumes after clear");
    endtask

    task automatic t_overflow_and_reset();
        recenter_by_clr();
        lead(4);
        rd_cycles(8);
        chk(fifo_err == 1'b1, "R5 overflow flagged", fifo_err, 1);
        rd_rst = 1;
        rd_cycles(3);
        rd_rst = 0;
        rd_cycles(16);
        chk(fifo_err == 1'b0, "R6 reset clears flag", fifo_err, 0);
        lag(3);
        rd_cycles(8);
        check_stream(16, "R11 centered after reset release");
    endtask

    task automatic t_lock_edges();
        int run = 0;
        int best = 0;
        recenter_by_clr();
        lag(3);
        tx_lock = 0;
        rd_cycles(4);
        check_stream(16, "R10 falling lock keeps position");
        for (int i = 0; i < 16; i++) begin
            @(negedge rd_clk);
            if (i == 0) tx_lock = 1;
            if (rd_data == 4'd0) run++;
            else run = 0;
            if (run > best) best = run;
        end
        chk(best >= 4, "R9 zero words during lock recenter", best, 4);
        check_stream(12, "R9 order after lock recenter");
        lag(3);
        rd_cycles(8);
        chk(fifo_err == 1'b0, "R9 drift window recentered", fifo_err, 0);
    endtask

    initial begin
        t_reset();
        t_drift_ok();
        t_underflow_and_sticky();
        t_overflow_and_reset();
        t_lock_edges();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule